// File: doc/BRIEF.md
# Masked Broadcast Memory Pair

This block connects a narrow external controller to an array of SIMD processing elements through two 128-bit word buffers. The controller puts words into the inbound buffer through a 64-bit write port, one half per clock. An instruction goes to every element at the same time. It carries a buffer opcode, an element mask, a buffer address and an element register address. A load copies one inbound buffer word into the addressed register of every element whose mask bit is set.

For the reverse direction, a store instruction copies one element's register into the outbound buffer. The controller then reads that buffer back through a 64-bit read port, one half per request. Each element is modelled as a register file only; its arithmetic is outside this block. The buffers are the only path between the controller and the elements.

Top module: `bcast_mem_pair`

## Requirements
- R1: After reset, `out_rd_data` is zero and `store_err` is low.
- R2: An inbound write beat with `in_wr_hi`=0 holds the low 64 bits. A beat with `in_wr_hi`=1 commits the 128-bit word {high beat, held low half} at the address given with the high beat.
- R3: A low beat alone leaves the inbound buffer unchanged. A second low beat before the high beat replaces the held half.
- R4: An instruction with `ins_op`=2'b01 (load) writes the inbound word at `ins_buf_addr` into register `ins_reg_addr` of every element whose `ins_mask` bit is set. Elements whose bit is clear keep their register contents.
- R5: An instruction with `ins_op`=2'b10 (store) writes register `ins_reg_addr` of the lowest-numbered selected element (mask bit 0 is element 0) into outbound word `ins_buf_addr`.
- R6: A read request with `out_rd_en` returns, on the next clock, the low half (`out_rd_hi`=0) or the high half (`out_rd_hi`=1) of the addressed outbound word. Without a request, `out_rd_data` holds its value.
- R7: A store with an all-zero mask, or any instruction with `ins_valid` low, leaves the outbound buffer unchanged.
- R8: `store_err` is high for exactly the cycle after a valid store whose mask has more than one bit set. After any other cycle it is low.
- R9: Opcodes 2'b00 and 2'b11 change neither the elements, the outbound buffer nor `store_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_wr_en | input | 1 | Inbound write beat valid |
| in_wr_hi | input | 1 | Beat half: 0 low, 1 high (commits the word) |
| in_wr_addr | input | 7 | Inbound word address |
| in_wr_data | input | 64 | Beat data |
| out_rd_en | input | 1 | Outbound read request |
| out_rd_hi | input | 1 | Half to return: 0 low, 1 high |
| out_rd_addr | input | 7 | Outbound word address |
| out_rd_data | output | 64 | Registered read data |
| ins_valid | input | 1 | Instruction valid |
| ins_op | input | 2 | Buffer opcode: 00 none, 01 load, 10 store, 11 none |
| ins_mask | input | 6 | Element select mask |
| ins_buf_addr | input | 7 | Buffer word address |
| ins_reg_addr | input | 7 | Element register address |
| store_err | output | 1 | Multi-element store flag |

## Verification
The bench targets the cases that a slightly wrong design gets wrong.

- **Half ordering.** A design that commits on the low beat, or that swaps the halves, returns a scrambled or stale word.
- **Extra low beats.** An orphan low beat must not disturb the buffer, and a repeated low beat must replace the held half. A design that writes early or keeps the first half fails here.
- **Load masks.** A multi-bit load must reach every selected element and leave the others untouched. This catches a design that decodes only one mask bit or writes everywhere.
- **Store conflicts.** A multi-bit store must take the lowest element and pulse `store_err` for exactly one cycle. An all-zero mask must leave the outbound word unchanged, and so must a dropped valid or a reserved opcode. These checks catch an inverted priority, a sticky flag, and writes with no selected element.

// File: rtl/bm_pair_pkg.sv
package bm_pair_pkg;
   typedef enum logic [1:0] {
      BOP_NONE  = 2'b00,
      BOP_LOAD  = 2'b01,
      BOP_STORE = 2'b10,
      BOP_RSVD  = 2'b11
   } bop_e;
endpackage

// File: rtl/bm_in_buf.sv
module bm_in_buf #(
   parameter int DATA_W = 128,
   parameter int BEAT_W = 64,
   parameter int DEPTH  = 128,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_hi,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BEAT_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_word
);
   logic [BEAT_W-1:0] lo_hold;
   logic [DATA_W-1:0] mem [DEPTH];

   // low half waits in a holding register until the high beat arrives
   always_ff @(posedge clk) begin
      if (!rst_n)
         lo_hold <= '0;
      else if (wr_en && !wr_hi)
         lo_hold <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_hi)
         mem[wr_addr] <= {wr_data, lo_hold};
   end

   assign rd_word = mem[rd_addr];
endmodule

// File: rtl/bm_pe_array.sv
module bm_pe_array #(
   parameter int DATA_W    = 128,
   parameter int NUM_PE    = 6,
   parameter int REG_DEPTH = 128,
   parameter bit LOW_WINS  = 1'b1,
   localparam int RAW      = $clog2(REG_DEPTH)
) (
   input  logic              clk,
   input  logic              ld_en,
   input  logic [NUM_PE-1:0] mask,
   input  logic [RAW-1:0]    reg_addr,
   input  logic [DATA_W-1:0] ld_word,
   output logic [DATA_W-1:0] st_word,
   output logic              st_multi
);
   logic [DATA_W-1:0] pe_rd [NUM_PE];

   for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
      logic [DATA_W-1:0] rf [REG_DEPTH];
      always_ff @(posedge clk) begin
         if (ld_en && mask[g])
            rf[reg_addr] <= ld_word;
      end
      assign pe_rd[g] = rf[reg_addr];
   end

   // priority select of the element that drives a store
   if (LOW_WINS) begin : g_low
      always_comb begin
         st_word = '0;
         for (int i = NUM_PE - 1; i >= 0; i--)
            if (mask[i]) st_word = pe_rd[i];
      end
   end else begin : g_high
      always_comb begin
         st_word = '0;
         for (int i = 0; i < NUM_PE; i++)
            if (mask[i]) st_word = pe_rd[i];
      end
   end

   assign st_multi = |(mask & (mask - NUM_PE'(1)));
endmodule

// File: rtl/bm_out_buf.sv
module bm_out_buf #(
   parameter int DATA_W = 128,
   parameter int BEAT_W = 64,
   parameter int DEPTH  = 128,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_en,
   input  logic [AW-1:0]     st_addr,
   input  logic [DATA_W-1:0] st_word,
   input  logic              rd_en,
   input  logic              rd_hi,
   input  logic [AW-1:0]     rd_addr,
   output logic [BEAT_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] sel_word;

   always_ff @(posedge clk) begin
      if (st_en)
         mem[st_addr] <= st_word;
   end

   assign sel_word = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_hi ? sel_word[DATA_W-1:BEAT_W] : sel_word[BEAT_W-1:0];
   end
endmodule

// File: rtl/bcast_mem_pair.sv
module bcast_mem_pair
   import bm_pair_pkg::*;
#(
   parameter int DATA_W    = 128,
   parameter int BEAT_W    = 64,
   parameter int BUF_DEPTH = 128,
   parameter int NUM_PE    = 6,
   parameter int REG_DEPTH = 128,
   parameter bit LOW_WINS  = 1'b1,
   localparam int AW       = $clog2(BUF_DEPTH),
   localparam int RAW      = $clog2(REG_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_wr_en,
   input  logic              in_wr_hi,
   input  logic [AW-1:0]     in_wr_addr,
   input  logic [BEAT_W-1:0] in_wr_data,
   input  logic              out_rd_en,
   input  logic              out_rd_hi,
   input  logic [AW-1:0]     out_rd_addr,
   output logic [BEAT_W-1:0] out_rd_data,
   input  logic              ins_valid,
   input  logic [1:0]        ins_op,
   input  logic [NUM_PE-1:0] ins_mask,
   input  logic [AW-1:0]     ins_buf_addr,
   input  logic [RAW-1:0]    ins_reg_addr,
   output logic              store_err
);
   if (DATA_W != 2 * BEAT_W) begin : g_bad_width
      $error("DATA_W must be exactly two beats");
   end
   if (NUM_PE < 1 || BUF_DEPTH < 2 || REG_DEPTH < 2) begin : g_bad_size
      $error("NUM_PE, BUF_DEPTH and REG_DEPTH out of range");
   end

   bop_e              op;
   logic              ld_en, st_sel, st_multi;
   logic [DATA_W-1:0] in_word, st_word;

   assign op     = bop_e'(ins_op);
   assign ld_en  = ins_valid && (op == BOP_LOAD);
   assign st_sel = ins_valid && (op == BOP_STORE);

   bm_in_buf #(.DATA_W(DATA_W), .BEAT_W(BEAT_W), .DEPTH(BUF_DEPTH)) u_in (
      .clk(clk), .rst_n(rst_n), .wr_en(in_wr_en), .wr_hi(in_wr_hi),
      .wr_addr(in_wr_addr), .wr_data(in_wr_data),
      .rd_addr(ins_buf_addr), .rd_word(in_word)
   );

   bm_pe_array #(.DATA_W(DATA_W), .NUM_PE(NUM_PE), .REG_DEPTH(REG_DEPTH),
                 .LOW_WINS(LOW_WINS)) u_pe (
      .clk(clk), .ld_en(ld_en), .mask(ins_mask), .reg_addr(ins_reg_addr),
      .ld_word(in_word), .st_word(st_word), .st_multi(st_multi)
   );

   bm_out_buf #(.DATA_W(DATA_W), .BEAT_W(BEAT_W), .DEPTH(BUF_DEPTH)) u_out (
      .clk(clk), .rst_n(rst_n), .st_en(st_sel && (|ins_mask)),
      .st_addr(ins_buf_addr), .st_word(st_word),
      .rd_en(out_rd_en), .rd_hi(out_rd_hi), .rd_addr(out_rd_addr),
      .rd_data(out_rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         store_err <= 1'b0;
      else
         store_err <= st_sel && st_multi;
   end
endmodule

// File: rtl/bm_pair_chk.sv
module bm_pair_chk #(
   parameter int BEAT_W = 64,
   parameter int NUM_PE = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_rd_en,
   input logic [BEAT_W-1:0] out_rd_data,
   input logic              ins_valid,
   input logic [1:0]        ins_op,
   input logic [NUM_PE-1:0] ins_mask,
   input logic              store_err
);
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_rd_en |=> $stable(out_rd_data)); // R6

   AST_ERR_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_op == 2'b10 && $countones(ins_mask) > 1) |=> store_err); // R8

   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_op == 2'b10 && $onehot0(ins_mask)) |=> !store_err); // R8

   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_valid || ins_op == 2'b00 || ins_op == 2'b11) |=> !store_err); // R9
endmodule

bind bcast_mem_pair bm_pair_chk #(.BEAT_W(BEAT_W), .NUM_PE(NUM_PE)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_rd_en(out_rd_en), .out_rd_data(out_rd_data),
   .ins_valid(ins_valid), .ins_op(ins_op), .ins_mask(ins_mask),
   .store_err(store_err)
);

// File: tb/bcast_mem_pair_test.sv
module bcast_mem_pair_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_wr_en = 0, in_wr_hi = 0;
   logic [6:0]  in_wr_addr = 0;
   logic [63:0] in_wr_data = 0;
   logic        out_rd_en = 0, out_rd_hi = 0;
   logic [6:0]  out_rd_addr = 0;
   logic [63:0] out_rd_data;
   logic        ins_valid = 0;
   logic [1:0]  ins_op = 0;
   logic [5:0]  ins_mask = 0;
   logic [6:0]  ins_buf_addr = 0, ins_reg_addr = 0;
   logic        store_err;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bcast_mem_pair uut (
      .clk(clk), .rst_n(rst_n),
      .in_wr_en(in_wr_en), .in_wr_hi(in_wr_hi), .in_wr_addr(in_wr_addr),
      .in_wr_data(in_wr_data),
      .out_rd_en(out_rd_en), .out_rd_hi(out_rd_hi), .out_rd_addr(out_rd_addr),
      .out_rd_data(out_rd_data),
      .ins_valid(ins_valid), .ins_op(ins_op), .ins_mask(ins_mask),
      .ins_buf_addr(ins_buf_addr), .ins_reg_addr(ins_reg_addr),
      .store_err(store_err)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic beat(input logic hi, input logic [6:0] a, input logic [63:0] d);
      @(negedge clk);
      in_wr_en = 1; in_wr_hi = hi; in_wr_addr = a; in_wr_data = d;
      @(negedge clk);
      in_wr_en = 0;
   endtask

   task automatic write_word(input logic [6:0] a, input logic [127:0] w);
      beat(1'b0, a, w[63:0]);
      beat(1'b1, a, w[127:64]);
   endtask

   task automatic issue(input logic v, input logic [1:0] op, input logic [5:0] m,
                        input logic [6:0] ba, input logic [6:0] ra, output logic err);
      @(negedge clk);
      ins_valid = v; ins_op = op; ins_mask = m; ins_buf_addr = ba; ins_reg_addr = ra;
      @(negedge clk);
      ins_valid = 0; ins_op = 0; ins_mask = 0;
      err = store_err;
   endtask

   task automatic read_word(input logic [6:0] a, output logic [127:0] w);
      @(negedge clk);
      out_rd_en = 1; out_rd_hi = 0; out_rd_addr = a;
      @(negedge clk);
      w[63:0] = out_rd_data;
      out_rd_hi = 1;
      @(negedge clk);
      w[127:64] = out_rd_data;
      out_rd_en = 0;
   endtask

   task automatic t_reset;
      chk("R1 rd_data", {64'h0, out_rd_data}, 128'h0);
      chk("R1 store_err", {127'h0, store_err}, 128'h0);
   endtask

   task automatic t_load_single;
      logic [127:0] w;
      logic e;
      write_word(7'd3, 128'hA1A2A3A4_A5A6A7A8_A9AAABAC_ADAEAFB0);
      issue(1, 2'b01, 6'b000100, 7'd3, 7'd5, e);
      issue(1, 2'b10, 6'b000100, 7'd10, 7'd5, e);
      chk("R8 single store no err", {127'h0, e}, 128'h0);
      read_word(7'd10, w);
      chk("R2 R4 R5 round trip", w, 128'hA1A2A3A4_A5A6A7A8_A9AAABAC_ADAEAFB0);
      chk("R6 high half", {64'h0, w[127:64]}, {64'h0, 64'hA1A2A3A4_A5A6A7A8});
   endtask

   task automatic t_low_beats;
      logic [127:0] w;
      logic e;
      write_word(7'd4, 128'h11112222_33334444_55556666_77778888);
      beat(1'b0, 7'd4, 64'hDEADDEAD_DEADDEAD);
      issue(1, 2'b01, 6'b000001, 7'd4, 7'd1, e);
      issue(1, 2'b10, 6'b000001, 7'd11, 7'd1, e);
      read_word(7'd11, w);
      chk("R3 orphan low beat", w, 128'h11112222_33334444_55556666_77778888);
      beat(1'b0, 7'd5, 64'h0BAD0BAD_0BAD0BAD);
      beat(1'b0, 7'd5, 64'hC0C0C0C0_C0C0C0C0);
      beat(1'b1, 7'd5, 64'h9999AAAA_BBBBCCCC);
      issue(1, 2'b01, 6'b000001, 7'd5, 7'd1, e);
      issue(1, 2'b10, 6'b000001, 7'd12, 7'd1, e);
      read_word(7'd12, w);
      chk("R3 R2 replaced low half", w, 128'h9999AAAA_BBBBCCCC_C0C0C0C0_C0C0C0C0);
   endtask

   task automatic t_multi_load;
      logic [127:0] w;
      logic e;
      write_word(7'd6, 128'hEEEE0000_EEEE0000_EEEE0000_EEEE0000);
      write_word(7'd7, 128'hD00DD00D_D00DD00D_D00DD00D_D00DD00D);
      issue(1, 2'b01, 6'b111111, 7'd6, 7'd9, e);
      issue(1, 2'b01, 6'b101001, 7'd7, 7'd9, e);
      for (int i = 0; i < 6; i++) begin
         issue(1, 2'b10, 6'(1 << i), 7'(20 + i), 7'd9, e);
         read_word(7'(20 + i), w);
         if (i == 0 || i == 3 || i == 5)
            chk("R4 selected element", w, 128'hD00DD00D_D00DD00D_D00DD00D_D00DD00D);
         else
            chk("R4 unselected element", w, 128'hEEEE0000_EEEE0000_EEEE0000_EEEE0000);
      end
   endtask

   task automatic t_store_priority;
      logic [127:0] w;
      logic e;
      write_word(7'd8, 128'hF1F1F1F1_F1F1F1F1_F1F1F1F1_F1F1F1F1);
      write_word(7'd9, 128'h46464646_46464646_46464646_46464646);
      issue(1, 2'b01, 6'b000010, 7'd8, 7'd2, e);
      issue(1, 2'b01, 6'b010000, 7'd9, 7'd2, e);
      issue(1, 2'b10, 6'b010010, 7'd30, 7'd2, e);
      chk("R8 multi store err", {127'h0, e}, 128'h1);
      @(negedge clk);
      chk("R8 err one cycle", {127'h0, store_err}, 128'h0);
      read_word(7'd30, w);
      chk("R5 lowest element wins", w, 128'hF1F1F1F1_F1F1F1F1_F1F1F1F1_F1F1F1F1);
   endtask

   task automatic t_no_effect;
      logic [127:0] w;
      logic e;
      issue(1, 2'b10, 6'b000000, 7'd30, 7'd9, e);
      chk("R7 zero-mask store no err", {127'h0, e}, 128'h0);
      read_word(7'd30, w);
      chk("R7 zero-mask store", w, 128'hF1F1F1F1_F1F1F1F1_F1F1F1F1_F1F1F1F1);
      issue(0, 2'b10, 6'b000001, 7'd30, 7'd9, e);
      read_word(7'd30, w);
      chk("R7 invalid instruction", w, 128'hF1F1F1F1_F1F1F1F1_F1F1F1F1_F1F1F1F1);
      issue(1, 2'b11, 6'b010010, 7'd30, 7'd9, e);
      chk("R9 reserved op no err", {127'h0, e}, 128'h0);
      read_word(7'd30, w);
      chk("R9 reserved op outbuf", w, 128'hF1F1F1F1_F1F1F1F1_F1F1F1F1_F1F1F1F1);
      // register 2 of element 1 must still hold its value after opcodes 11 and 00
      issue(1, 2'b11, 6'b000010, 7'd6, 7'd2, e);
      issue(1, 2'b00, 6'b000010, 7'd6, 7'd2, e);
      issue(1, 2'b10, 6'b000010, 7'd31, 7'd2, e);
      read_word(7'd31, w);
      chk("R9 element untouched", w, 128'hF1F1F1F1_F1F1F1F1_F1F1F1F1_F1F1F1F1);
   endtask

   task automatic t_read_hold;
      @(negedge clk);
      out_rd_en = 0; out_rd_hi = 0; out_rd_addr = 7'd10;
      @(negedge clk);
      @(negedge clk);
      chk("R6 hold without request", {64'h0, out_rd_data}, {64'h0, 64'hF1F1F1F1_F1F1F1F1});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_load_single();
      t_low_beats();
      t_multi_load();
      t_store_priority();
      t_no_effect();
      t_read_hold();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule